// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Sequencer

This block drives a two-channel, simultaneous-sampling serial analog-to-digital converter from the system clock domain. A single conversion strobe makes the converter sample both channels at the same moment. The block then issues a fixed 34-cycle serial clock burst, reads the converter's data line, and assembles two 14-bit two's-complement words, one for channel A and one for channel B. Both words appear on parallel outputs, marked by a one-cycle valid pulse.

The converter returns the result of the strobe before the current one. The block therefore never flags the frame that follows a reset, and each later frame reports the conversion started one strobe earlier. A frame can be launched by a single-cycle start request or repeated back to back while a free-run enable is held. The serial clock speed comes from a divider setting, which is latched at each strobe and clamped to a floor. The floor keeps the per-channel sample rate within the converter's limit of about 1.5 MHz. A busy flag covers the whole frame, so other users of a shared serial bus can stay off it until the converter has released its data line.

Top module: `dual_adc_capture`

## Requirements
- R1: After reset the conversion strobe, serial clock, busy flag and valid pulse are low and both sample outputs are zero.
- R2: A frame starts when `start_i` or `run_en_i` is high while idle. The conversion strobe is then high for exactly one serial clock period (low half then high half), and the serial clock falls at the same moment the strobe falls.
- R3: After the strobe falls, exactly 34 rising serial clock edges are issued. The serial clock then returns low and busy drops. The serial clock stays low whenever busy is low.
- R4: The data line is sampled on rising serial clock edges, numbered from 0 after the strobe. Edges 2 to 15 give channel A and edges 18 to 31 give channel B, both MSB first. Bits at edges 0, 1, 16, 17, 32 and 33 have no effect on either output.
- R5: The first frame after reset produces no valid pulse. Every later frame reports the values sampled at the previous strobe.
- R6: The valid pulse lasts one system clock. It starts in the clock in which the 32nd post-strobe rising edge (the last channel-B bit) appears on `sck_o`. Both outputs keep their values until the next valid pulse.
- R7: The divider value is latched at the strobe and raised to `DIV_MIN` (default 1) if it is smaller. Each half period of the serial clock, strobe phase included, then lasts the latched value plus one system clocks.
- R8: Busy is high from the strobe until the end of the frame. A start request while busy launches no extra frame.
- R9: While `run_en_i` stays high, frames repeat with exactly one idle system clock between the end of one frame and the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one frame when idle |
| run_en_i | input | 1 | Keep launching frames back to back |
| div_i | input | DIV_W | Serial clock half-period setting, latched at each strobe |
| miso_i | input | 1 | Converter serial data |
| conv_o | output | 1 | Conversion strobe to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Frame in progress; shared bus occupied |
| samp_a_o | output | 14 | Channel A sample, two's complement |
| samp_b_o | output | 14 | Channel B sample, two's complement |
| samp_valid_o | output | 1 | One-cycle pulse when new samples are presented |

## Verification
Some properties are checked on every cycle by the embedded properties. These are: the serial clock is quiet while idle, the strobe only appears during a frame and ends on a serial clock fall, the bit counter never passes the frame length, the latched divider stays constant through a frame, the valid pulse is single-cycle and falls in a frame, and the outputs stay still between valid pulses. Other behaviour can only be shown by the bench, which plays the converter's part with a one-strobe delay. This covers the bit ordering, whether idle-slot bits are ignored, the discarded first frame after reset, the strobe width under divider clamping, the 34-edge count, the start request that is ignored while busy, and the one-cycle gap in free-run mode.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  localparam int WORD_W     = 14;
  localparam int GAP_W      = 2;
  localparam int FRAME_CLKS = 3 * GAP_W + 2 * WORD_W;
  localparam int CNT_W      = $clog2(FRAME_CLKS + 1);

  typedef logic [CNT_W-1:0]  bitcnt_t;
  typedef logic [WORD_W-1:0] sample_t;

  // rising-edge indices after the strobe (slot order is behaviour)
  localparam bitcnt_t A_FIRST   = bitcnt_t'(GAP_W);
  localparam bitcnt_t A_LAST    = bitcnt_t'(GAP_W + WORD_W - 1);
  localparam bitcnt_t B_FIRST   = bitcnt_t'(2 * GAP_W + WORD_W);
  localparam bitcnt_t B_LAST    = bitcnt_t'(2 * GAP_W + 2 * WORD_W - 1);
  localparam bitcnt_t EDGES_ALL = bitcnt_t'(FRAME_CLKS);

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CONV,
    SEQ_SHIFT
  } seq_state_e;

endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             rise_tk_o,
  output logic             fall_tk_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             wrap;

  assign wrap = run_i && (cnt_q == half_i);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run_i) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o     = sck_q;
  assign rise_tk_o = wrap && !sck_q;
  assign fall_tk_o = wrap && sck_q;

  // R7: half-period counter never runs past the latched limit
  p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= half_i));

  // R3: a stopped generator leaves the clock low
  p_sck_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sck_q);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_cap_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rise_tk_i,
  input  logic             fall_tk_i,
  output logic             shift_o,
  output bitcnt_t          bitcnt_o,
  output logic [DIV_W-1:0] half_o,
  output logic             conv_o,
  output logic             busy_o,
  output logic             frame_end_o
);

  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(DIV_MIN);

  seq_state_e       state_q, state_d;
  bitcnt_t          bitcnt_q, bitcnt_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W-1:0] div_eff;
  logic             launch;
  logic             frame_end;

  assign div_eff   = (div_i < DIV_FLOOR) ? DIV_FLOOR : div_i;
  assign launch    = (state_q == SEQ_IDLE) && (start_i || run_en_i);
  assign frame_end = (state_q == SEQ_SHIFT) && fall_tk_i && (bitcnt_q == EDGES_ALL);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    half_d   = half_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (launch) begin
          state_d  = SEQ_CONV;
          bitcnt_d = '0;
          half_d   = div_eff;
        end
      end
      SEQ_CONV: begin
        if (fall_tk_i) state_d = SEQ_SHIFT;
      end
      SEQ_SHIFT: begin
        if (rise_tk_i) bitcnt_d = bitcnt_q + 1'b1;
        if (frame_end) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      bitcnt_q <= '0;
      half_q   <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      half_q   <= half_d;
    end
  end

  assign shift_o     = (state_q == SEQ_SHIFT);
  assign conv_o      = (state_q == SEQ_CONV);
  assign busy_o      = (state_q != SEQ_IDLE);
  assign bitcnt_o    = bitcnt_q;
  assign half_o      = half_q;
  assign frame_end_o = frame_end;

  // R3: no more than the frame's edge count is ever issued
  p_bitcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= EDGES_ALL);

  // R7: divider setting is frozen for the whole frame
  p_half_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(half_q));

endmodule

// File: rtl/adc_word_capture.sv
module adc_word_capture
  import adc_cap_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    shift_i,
  input  logic    rise_tk_i,
  input  bitcnt_t bitcnt_i,
  input  logic    miso_i,
  input  logic    frame_end_i,
  output sample_t samp_a_o,
  output sample_t samp_b_o,
  output logic    valid_o
);

  sample_t           sh_a_q, sh_a_d;
  logic [WORD_W-2:0] sh_b_q, sh_b_d;
  sample_t           out_a_q, out_a_d;
  sample_t           out_b_q, out_b_d;
  logic              valid_q, valid_d;
  logic              primed_q, primed_d;
  logic              edge_ok, take_a, take_b, last_b, publish;

  assign edge_ok = shift_i && rise_tk_i;
  assign take_a  = edge_ok && (bitcnt_i >= A_FIRST) && (bitcnt_i <= A_LAST);
  assign take_b  = edge_ok && (bitcnt_i >= B_FIRST) && (bitcnt_i <  B_LAST);
  assign last_b  = edge_ok && (bitcnt_i == B_LAST);
  assign publish = last_b && primed_q;

  always_comb begin
    sh_a_d   = take_a ? {sh_a_q[WORD_W-2:0], miso_i} : sh_a_q;
    sh_b_d   = take_b ? {sh_b_q[WORD_W-3:0], miso_i} : sh_b_q;
    out_a_d  = publish ? sh_a_q : out_a_q;
    out_b_d  = publish ? {sh_b_q, miso_i} : out_b_q;
    valid_d  = publish;
    primed_d = primed_q | frame_end_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a_q   <= '0;
      sh_b_q   <= '0;
      out_a_q  <= '0;
      out_b_q  <= '0;
      valid_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      sh_a_q   <= sh_a_d;
      sh_b_q   <= sh_b_d;
      out_a_q  <= out_a_d;
      out_b_q  <= out_b_d;
      valid_q  <= valid_d;
      primed_q <= primed_d;
    end
  end

  assign samp_a_o = out_a_q;
  assign samp_b_o = out_b_q;
  assign valid_o  = valid_q;

  // R6: valid is a single-cycle pulse
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R6: outputs hold between valid pulses
  p_outputs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(out_a_q) && $stable(out_b_q)));

  // R5: nothing is presented before a full frame has completed
  p_primed_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> primed_q);

endmodule

// File: rtl/dual_adc_capture.sv
module dual_adc_capture
  import adc_cap_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              run_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] samp_a_o,
  output logic [WORD_W-1:0] samp_b_o,
  output logic              samp_valid_o
);

  logic             rst_meta_q, rst_core_q;
  logic             rise_tk, fall_tk;
  logic             shift_on, frame_end;
  bitcnt_t          bitcnt;
  logic [DIV_W-1:0] half;
  logic             busy;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  adc_frame_seq #(
    .DIV_W   (DIV_W),
    .DIV_MIN (DIV_MIN)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_core_q),
    .start_i     (start_i),
    .run_en_i    (run_en_i),
    .div_i       (div_i),
    .rise_tk_i   (rise_tk),
    .fall_tk_i   (fall_tk),
    .shift_o     (shift_on),
    .bitcnt_o    (bitcnt),
    .half_o      (half),
    .conv_o      (conv_o),
    .busy_o      (busy),
    .frame_end_o (frame_end)
  );

  adc_sck_gen #(
    .DIV_W (DIV_W)
  ) sck_i (
    .clk       (clk),
    .rst_n     (rst_core_q),
    .run_i     (busy),
    .half_i    (half),
    .sck_o     (sck_o),
    .rise_tk_o (rise_tk),
    .fall_tk_o (fall_tk)
  );

  adc_word_capture cap_i (
    .clk         (clk),
    .rst_n       (rst_core_q),
    .shift_i     (shift_on),
    .rise_tk_i   (rise_tk),
    .bitcnt_i    (bitcnt),
    .miso_i      (miso_i),
    .frame_end_i (frame_end),
    .samp_a_o    (samp_a_o),
    .samp_b_o    (samp_b_o),
    .valid_o     (samp_valid_o)
  );

  assign busy_o = busy;

  // R3: serial clock is parked low outside a frame
  p_idle_sck_low_r3: assert property (@(posedge clk) disable iff (!rst_core_q)
    !busy |-> !sck_o);

  // R2: the strobe ends together with a serial clock fall
  p_conv_ends_low_r2: assert property (@(posedge clk) disable iff (!rst_core_q)
    $fell(conv_o) |-> !sck_o);

  // R8: the strobe only occurs inside a busy frame
  p_conv_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_core_q)
    conv_o |-> busy);

  // R6: valid appears with the serial clock high, inside a frame
  p_valid_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_core_q)
    samp_valid_o |-> (busy && sck_o && !conv_o));

endmodule

// File: tb/dual_adc_capture_tb_top.sv
module dual_adc_capture_tb_top;

  localparam int DIV_W = 8;

  // {channel A, channel B} analog values the converter model samples per strobe
  localparam logic [27:0] VEC [8] = '{
    {14'h1FFF, 14'h2000},
    {14'h0000, 14'h3FFF},
    {14'h2AAA, 14'h1555},
    {14'h0001, 14'h2001},
    {14'h3FFE, 14'h0002},
    {14'h1234, 14'h0ABC},
    {14'h2000, 14'h1FFF},
    {14'h3C0F, 14'h03F0}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             run_en;
  logic [DIV_W-1:0] div;
  logic             miso;
  logic             conv, sck, busy, valid;
  logic [13:0]      samp_a, samp_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dual_adc_capture #(.DIV_W(DIV_W), .DIV_MIN(1)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .run_en_i     (run_en),
    .div_i        (div),
    .miso_i       (miso),
    .conv_o       (conv),
    .sck_o        (sck),
    .busy_o       (busy),
    .samp_a_o     (samp_a),
    .samp_b_o     (samp_b),
    .samp_valid_o (valid)
  );

  // converter model: returns previous strobe's values, data changes after SCK falls
  logic [1:0]  idle_pat = 2'b11;
  logic [33:0] frm = '0;
  logic [13:0] held_a = 14'h0BAD, held_b = 14'h0BAD;
  int m_idx = 0, m_r = 0, m_i = 0;
  bit m_pconv = 0, m_psck = 0;

  always @(negedge clk) begin
    if (conv && !m_pconv) begin
      frm    = {idle_pat, held_a, idle_pat, held_b, idle_pat};
      held_a = VEC[m_idx % 8][27:14];
      held_b = VEC[m_idx % 8][13:0];
      m_idx++;
      m_r = 0;
      m_i = 0;
    end else if (!conv) begin
      if (sck && !m_psck) m_r++;
      if (!sck && m_psck && m_r > 0 && m_r < 34) m_i = m_r;
    end
    m_pconv = conv;
    m_psck  = sck;
  end

  assign miso = frm[6'(33 - m_i)];

  // port monitor
  bit p_conv = 0, p_sck = 0, p_busy = 0, p_valid = 0;
  int conv_run = 0, conv_w_last = 0, conv_cnt = 0;
  int rises = 0, rises_last = 0, rises_at_valid = 0;
  int hi_run = 0, hi_last = 0;
  int gap_run = 0, gap_last = 0;
  int valid_run = 0, valid_w_last = 0, valid_total = 0;
  logic [13:0] last_a = '0, last_b = '0;

  always @(negedge clk) begin
    if (conv && !p_conv) begin
      rises    = 0;
      conv_run = 0;
      conv_cnt++;
      gap_last = gap_run;
    end
    if (conv) conv_run++;
    if (!conv && p_conv) conv_w_last = conv_run;
    if (sck && !p_sck && !conv) rises++;
    if (sck) hi_run = p_sck ? hi_run + 1 : 1;
    else if (p_sck) hi_last = hi_run;
    if (!busy && p_busy) rises_last = rises;
    if (!busy) gap_run = p_busy ? 1 : gap_run + 1;
    if (valid) begin
      valid_run++;
      valid_total++;
      last_a         = samp_a;
      last_b         = samp_b;
      rises_at_valid = rises;
    end else begin
      if (p_valid) valid_w_last = valid_run;
      valid_run = 0;
    end
    p_conv  = conv;
    p_sck   = sck;
    p_busy  = busy;
    p_valid = valid;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_frame();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_idle();
  endtask

  initial begin
    int vt, cc;
    rst_n  = 1'b0;
    start  = 1'b0;
    run_en = 1'b0;
    div    = 8'd1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 ctrl", {28'h0, conv, sck, busy, valid}, 32'h0);
    chk("R1 samp_a", 32'(samp_a), 32'h0);
    chk("R1 samp_b", 32'(samp_b), 32'h0);

    // table walk; idle slots alternate 00/11 to show they are ignored (R4)
    for (int i = 0; i < 9; i++) begin
      idle_pat = (i % 2 == 1) ? 2'b11 : 2'b00;
      vt = valid_total;
      run_frame();
      if (i == 0) begin
        chk("R5 first frame no valid", 32'(valid_total - vt), 32'd0);
        chk("R3 edge count", 32'(rises_last), 32'd34);
        chk("R2 strobe width", 32'(conv_w_last), 32'd4);
        chk("R3 idle after frame", {30'h0, sck, busy}, 32'h0);
      end else begin
        chk("R5 one valid per frame", 32'(valid_total - vt), 32'd1);
        chk("R4 channel A", 32'(last_a), 32'(VEC[i-1][27:14]));
        chk("R4 channel B", 32'(last_b), 32'(VEC[i-1][13:0]));
      end
    end
    chk("R6 valid width", 32'(valid_w_last), 32'd1);
    chk("R6 valid on last B edge", 32'(rises_at_valid), 32'd32);

    // R6: hold between pulses
    repeat (20) @(negedge clk);
    chk("R6 hold A", 32'(samp_a), 32'(VEC[7][27:14]));
    chk("R6 hold B", 32'(samp_b), 32'(VEC[7][13:0]));

    // R8: start while busy is ignored
    cc = conv_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8 busy mid frame", 32'(busy), 32'd1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R8 single frame", 32'(conv_cnt - cc), 32'd1);

    // R7: divider clamp and half period
    div = 8'd0;
    run_frame();
    chk("R7 clamped strobe width", 32'(conv_w_last), 32'd4);
    div = 8'd3;
    run_frame();
    chk("R7 strobe width div3", 32'(conv_w_last), 32'd8);
    chk("R7 high phase div3", 32'(hi_last), 32'd4);
    div = 8'd1;

    // R9: free-run
    cc = conv_cnt;
    @(negedge clk) run_en = 1'b1;
    while (conv_cnt < cc + 3) @(negedge clk);
    run_en = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9 frame count", 32'(conv_cnt - cc), 32'd3);
    chk("R9 idle gap", 32'(gap_last), 32'd1);
    chk("R9 data A", 32'(last_a), 32'(VEC[(conv_cnt - 2) % 8][27:14]));
    chk("R9 data B", 32'(last_b), 32'(VEC[(conv_cnt - 2) % 8][13:0]));

    // R5: reset mid-frame, next frame again discarded
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {29'h0, conv, sck, busy}, 32'h0);
    vt = valid_total;
    run_frame();
    chk("R5 first frame after reset", 32'(valid_total - vt), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule